// File: doc/BRIEF.md
# Fixed-Format Instruction Decoder

This block turns one 32-bit instruction word into the operand selects and control strobes a pipeline needs. The word always splits the same way: a 4-bit primary opcode in bits [31:28], a destination register field in [27:24], a first source field in [23:20], a second source field in [19:16] and a 16-bit immediate in [15:0]. The primary opcode picks one of eight instruction classes. The class then decides which field carries the 4-bit secondary operation code. For register-register ALU and compare operations it is the low immediate nibble. For stores and conditional branches it is the destination slot. For immediate ALU, compare-immediate, load and jump-and-link it is the second-source slot.

The decoder also sign-extends the immediate and forms the PC-relative branch target. It flags any encoding that is not assigned, and such an encoding cannot write anything. All results are registered once, in a two-process style: a combinational stage computes the next values, and a flop stage holds them. A fetch stage presents the word and its PC. One clock later, the execute stage consumes the registered fields.

Top module: `instr_decoder`

## Requirements
- R1: `imm_o` is bits [15:0] of the word sign-extended to 32 bits. `br_target_o` is pc + 4 + 4*sign-extended immediate. Both are produced for every word, legal or not.
- R2: Primary opcode 0000 (register ALU) takes the secondary code from bits [3:0]. The legal codes are add 0000, sub 0001, and 0100, or 0101, xor 0110, nand 1100, nor 1101 and xnor 1110. It enables both sources and writes rd with write-back select ALU (code 0). Bits [15:4] that are not zero make the word illegal.
- R3: Opcode 0010 (register compare) takes its code from bits [3:0], under the same zero rule for [15:4]. Opcode 1010 (compare-immediate) takes its code from the rt slot. Both write rd with write-back select COMPARE (code 3). Compare-immediate also sets `alu_imm_o`. The legal compare codes are every value except 0100 and 1100.
- R4: Opcode 1000 (ALU-immediate) takes its code from the rt slot. The legal codes are the R2 set plus move-high 1011. It enables rs only, sets `alu_imm_o` and writes rd with select ALU.
- R5: Opcode 1001 (load) requires code 0000 in the rt slot. It enables rs, sets `alu_imm_o` and `mem_rd_o`, and writes rd with select MEMORY (code 1).
- R6: Opcode 0101 (store) requires code 0000 in the rd slot. It enables rs (address) and rt (data), sets `alu_imm_o` and `mem_wr_o`, and writes no register.
- R7: Opcode 0110 (conditional branch) takes a compare code (R3 set) from the rd slot. It enables rs and rt, sets `branch_o`, writes no register and leaves `alu_imm_o` low.
- R8: Opcode 1011 (jump-and-link) requires code 0000 in the rt slot. It enables rs, sets `alu_imm_o` and `jal_o`, and writes rd with select LINK (code 2).
- R9: Primary opcodes 0001, 0011, 0100, 0111, 1100, 1101, 1110 and 1111 raise `illegal_o`. They clear every enable, index, code and strobe.
- R10: An unassigned secondary code under an assigned opcode raises `illegal_o`, with every enable, index, code and strobe cleared.
- R11: Every output shows the decode of the word present at the previous rising clock edge. While `rst_n` is low, all outputs are zero.
- R12: A register index whose enable is low reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Byte address of the instruction |
| rs_idx_o | output | 4 | First source register |
| rs_en_o | output | 1 | First source is read |
| rt_idx_o | output | 4 | Second source register |
| rt_en_o | output | 1 | Second source is read |
| rd_idx_o | output | 4 | Destination register |
| rd_we_o | output | 1 | Register write enable |
| sec_op_o | output | 4 | Secondary operation code |
| imm_o | output | 32 | Sign-extended immediate |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 link, 3 compare |
| alu_imm_o | output | 1 | Second ALU operand is the immediate |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| branch_o | output | 1 | Conditional branch |
| jal_o | output | 1 | Jump-and-link |
| illegal_o | output | 1 | Unassigned encoding |
| br_target_o | output | 32 | PC-relative branch target |

## Verification
Every output is due exactly one rising edge after its word is applied. The bench drives the word and PC on a falling edge. It then waits one full period and compares all outputs on the following falling edge, well clear of the register update. The reset check samples while reset is held and a legal word is applied, so a decode that leaks past the flops would show. The checker's time-relating properties only look back once a clock has passed outside reset.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int WORD_W = 32;
    localparam int OP_W   = 4;
    localparam int REG_W  = 4;
    localparam int SEC_W  = 4;
    localparam int IMM_W  = 16;

    localparam logic [OP_W-1:0] OP_ALUR  = 4'b0000;
    localparam logic [OP_W-1:0] OP_CMPR  = 4'b0010;
    localparam logic [OP_W-1:0] OP_STORE = 4'b0101;
    localparam logic [OP_W-1:0] OP_BCOND = 4'b0110;
    localparam logic [OP_W-1:0] OP_ALUI  = 4'b1000;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'b1001;
    localparam logic [OP_W-1:0] OP_CMPI  = 4'b1010;
    localparam logic [OP_W-1:0] OP_JAL   = 4'b1011;

    localparam logic [SEC_W-1:0] SEC_MVHI = 4'b1011;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2,
        WB_CMP  = 2'd3
    } wb_sel_e;

    typedef enum logic [3:0] {
        CL_NONE, CL_ALUR, CL_CMPR, CL_STORE, CL_BCOND,
        CL_ALUI, CL_LOAD, CL_CMPI, CL_JAL
    } op_class_e;

    typedef struct packed {
        logic [REG_W-1:0] rs_idx;
        logic             rs_en;
        logic [REG_W-1:0] rt_idx;
        logic             rt_en;
        logic [REG_W-1:0] rd_idx;
        logic             rd_we;
        logic [SEC_W-1:0] sec;
        logic [WORD_W-1:0] imm;
        wb_sel_e          wb_sel;
        logic             alu_imm;
        logic             mem_rd;
        logic             mem_wr;
        logic             branch;
        logic             jal;
        logic             illegal;
    } dec_t;

    function automatic logic alu_code_ok(input logic [SEC_W-1:0] c, input logic allow_hi);
        case (c)
            4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b0110,
            4'b1100, 4'b1101, 4'b1110: alu_code_ok = 1'b1;
            SEC_MVHI:                  alu_code_ok = allow_hi;
            default:                   alu_code_ok = 1'b0;
        endcase
    endfunction

    function automatic logic cmp_code_ok(input logic [SEC_W-1:0] c);
        cmp_code_ok = (c != 4'b0100) && (c != 4'b1100);
    endfunction

endpackage

// File: rtl/dec_fields.sv
module dec_fields
    import dec_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int W_IMM  = IMM_W,
    parameter int W_SEC  = SEC_W
) (
    input  logic [W_WORD-1:0] word_i,
    output logic [OP_W-1:0]   op1_o,
    output logic [REG_W-1:0]  rd_o,
    output logic [REG_W-1:0]  rs_o,
    output logic [REG_W-1:0]  rt_o,
    output logic [W_SEC-1:0]  imm_lo_o,
    output logic              pad_nz_o,
    output logic [W_WORD-1:0] imm_ext_o
);
    localparam int EXT_W = W_WORD - W_IMM;

    assign op1_o    = word_i[W_WORD-1 -: OP_W];
    assign rd_o     = word_i[W_WORD-OP_W-1 -: REG_W];
    assign rs_o     = word_i[W_WORD-OP_W-REG_W-1 -: REG_W];
    assign rt_o     = word_i[W_WORD-OP_W-2*REG_W-1 -: REG_W];
    assign imm_lo_o = word_i[W_SEC-1:0];
    assign pad_nz_o = |word_i[W_IMM-1:W_SEC];

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext_o = {{EXT_W{word_i[W_IMM-1]}}, word_i[W_IMM-1:0]};
        end else begin : g_noext
            assign imm_ext_o = word_i[W_WORD-1:0];
        end
    endgenerate
endmodule

// File: rtl/dec_class.sv
module dec_class
    import dec_pkg::*;
(
    input  logic [OP_W-1:0]  op1_i,
    input  logic [REG_W-1:0] rd_i,
    input  logic [REG_W-1:0] rt_i,
    input  logic [SEC_W-1:0] imm_lo_i,
    input  logic             pad_nz_i,
    output op_class_e        cls_o,
    output logic [SEC_W-1:0] sec_o,
    output logic             sec_ok_o
);
    always_comb begin
        cls_o    = CL_NONE;
        sec_o    = '0;
        sec_ok_o = 1'b0;
        case (op1_i)
            OP_ALUR: begin
                cls_o    = CL_ALUR;
                sec_o    = imm_lo_i;
                sec_ok_o = !pad_nz_i && alu_code_ok(imm_lo_i, 1'b0);
            end
            OP_CMPR: begin
                cls_o    = CL_CMPR;
                sec_o    = imm_lo_i;
                sec_ok_o = !pad_nz_i && cmp_code_ok(imm_lo_i);
            end
            OP_STORE: begin
                cls_o    = CL_STORE;
                sec_o    = rd_i;
                sec_ok_o = (rd_i == '0);
            end
            OP_BCOND: begin
                cls_o    = CL_BCOND;
                sec_o    = rd_i;
                sec_ok_o = cmp_code_ok(rd_i);
            end
            OP_ALUI: begin
                cls_o    = CL_ALUI;
                sec_o    = rt_i;
                sec_ok_o = alu_code_ok(rt_i, 1'b1);
            end
            OP_LOAD: begin
                cls_o    = CL_LOAD;
                sec_o    = rt_i;
                sec_ok_o = (rt_i == '0);
            end
            OP_CMPI: begin
                cls_o    = CL_CMPI;
                sec_o    = rt_i;
                sec_ok_o = cmp_code_ok(rt_i);
            end
            OP_JAL: begin
                cls_o    = CL_JAL;
                sec_o    = rt_i;
                sec_ok_o = (rt_i == '0);
            end
            default: begin
                cls_o    = CL_NONE;
            end
        endcase
    end
endmodule

// File: rtl/dec_target.sv
module dec_target #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] imm_ext_i,
    output logic [PC_W-1:0] target_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    assign target_o = pc_i + STEP + {imm_ext_i[PC_W-3:0], 2'b00};
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import dec_pkg::*;
#(
    parameter int PC_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [REG_W-1:0]  rs_idx_o,
    output logic              rs_en_o,
    output logic [REG_W-1:0]  rt_idx_o,
    output logic              rt_en_o,
    output logic [REG_W-1:0]  rd_idx_o,
    output logic              rd_we_o,
    output logic [SEC_W-1:0]  sec_op_o,
    output logic [WORD_W-1:0] imm_o,
    output logic [1:0]        wb_sel_o,
    output logic              alu_imm_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              branch_o,
    output logic              jal_o,
    output logic              illegal_o,
    output logic [PC_W-1:0]   br_target_o
);
    logic [OP_W-1:0]   op1;
    logic [REG_W-1:0]  f_rd, f_rs, f_rt;
    logic [SEC_W-1:0]  imm_lo;
    logic              pad_nz;
    logic [WORD_W-1:0] imm_ext;
    op_class_e         cls;
    logic [SEC_W-1:0]  sec;
    logic              sec_ok;
    logic [PC_W-1:0]   tgt;

    dec_t            dec_d, dec_q;
    logic [PC_W-1:0] tgt_d, tgt_q;

    dec_fields u_fields (
        .word_i    (instr_i),
        .op1_o     (op1),
        .rd_o      (f_rd),
        .rs_o      (f_rs),
        .rt_o      (f_rt),
        .imm_lo_o  (imm_lo),
        .pad_nz_o  (pad_nz),
        .imm_ext_o (imm_ext)
    );

    dec_class u_class (
        .op1_i    (op1),
        .rd_i     (f_rd),
        .rt_i     (f_rt),
        .imm_lo_i (imm_lo),
        .pad_nz_i (pad_nz),
        .cls_o    (cls),
        .sec_o    (sec),
        .sec_ok_o (sec_ok)
    );

    dec_target #(.PC_W(PC_W)) u_target (
        .pc_i      (pc_i),
        .imm_ext_i (imm_ext[PC_W-1:0]),
        .target_o  (tgt)
    );

    always_comb begin
        dec_d        = '0;
        dec_d.imm    = imm_ext;
        dec_d.wb_sel = WB_ALU;
        tgt_d        = tgt;
        if ((cls != CL_NONE) && sec_ok) begin
            dec_d.sec = sec;
            case (cls)
                CL_ALUR, CL_CMPR: begin
                    dec_d.rs_en  = 1'b1;
                    dec_d.rt_en  = 1'b1;
                    dec_d.rd_we  = 1'b1;
                    dec_d.wb_sel = (cls == CL_CMPR) ? WB_CMP : WB_ALU;
                end
                CL_ALUI, CL_CMPI: begin
                    dec_d.rs_en   = 1'b1;
                    dec_d.rd_we   = 1'b1;
                    dec_d.alu_imm = 1'b1;
                    dec_d.wb_sel  = (cls == CL_CMPI) ? WB_CMP : WB_ALU;
                end
                CL_LOAD: begin
                    dec_d.rs_en   = 1'b1;
                    dec_d.rd_we   = 1'b1;
                    dec_d.alu_imm = 1'b1;
                    dec_d.mem_rd  = 1'b1;
                    dec_d.wb_sel  = WB_MEM;
                end
                CL_STORE: begin
                    dec_d.rs_en   = 1'b1;
                    dec_d.rt_en   = 1'b1;
                    dec_d.alu_imm = 1'b1;
                    dec_d.mem_wr  = 1'b1;
                end
                CL_BCOND: begin
                    dec_d.rs_en  = 1'b1;
                    dec_d.rt_en  = 1'b1;
                    dec_d.branch = 1'b1;
                end
                CL_JAL: begin
                    dec_d.rs_en   = 1'b1;
                    dec_d.rd_we   = 1'b1;
                    dec_d.alu_imm = 1'b1;
                    dec_d.jal     = 1'b1;
                    dec_d.wb_sel  = WB_LINK;
                end
                default: begin
                    dec_d.illegal = 1'b1;
                end
            endcase
        end else begin
            dec_d.illegal = 1'b1;
        end
        dec_d.rs_idx = dec_d.rs_en ? f_rs : '0;
        dec_d.rt_idx = dec_d.rt_en ? f_rt : '0;
        dec_d.rd_idx = dec_d.rd_we ? f_rd : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
            tgt_q <= '0;
        end else begin
            dec_q <= dec_d;
            tgt_q <= tgt_d;
        end
    end

    assign rs_idx_o    = dec_q.rs_idx;
    assign rs_en_o     = dec_q.rs_en;
    assign rt_idx_o    = dec_q.rt_idx;
    assign rt_en_o     = dec_q.rt_en;
    assign rd_idx_o    = dec_q.rd_idx;
    assign rd_we_o     = dec_q.rd_we;
    assign sec_op_o    = dec_q.sec;
    assign imm_o       = dec_q.imm;
    assign wb_sel_o    = dec_q.wb_sel;
    assign alu_imm_o   = dec_q.alu_imm;
    assign mem_rd_o    = dec_q.mem_rd;
    assign mem_wr_o    = dec_q.mem_wr;
    assign branch_o    = dec_q.branch;
    assign jal_o       = dec_q.jal;
    assign illegal_o   = dec_q.illegal;
    assign br_target_o = tgt_q;
endmodule

// File: rtl/dec_checker.sv
module dec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_in,
    input logic [11:0] pad_in,
    input logic [3:0]  rt_in,
    input logic        rd_we,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        branch,
    input logic        jal,
    input logic        illegal,
    input logic [1:0]  wb_sel,
    input logic        rt_en,
    input logic [3:0]  rt_idx
);
    logic primed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(rd_we || mem_rd || mem_wr || branch || jal)); // R9

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R5

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !rd_we); // R6

    AST_BRANCH_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        branch |-> !rd_we); // R7

    AST_JAL_LINKS: assert property (@(posedge clk) disable iff (!rst_n)
        jal |-> (rd_we && wb_sel == 2'd2)); // R8

    AST_UNUSED_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_en |-> (rt_idx == 4'd0)); // R12

    AST_ALUR_PAD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(rst_n) && $past(op_in == 4'b0000 && pad_in != 12'd0)) |-> illegal); // R2

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(rst_n) && $past(op_in == 4'b1001 && rt_in == 4'd0)) |-> mem_rd); // R11
endmodule

bind instr_decoder dec_checker u_dec_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_in   (instr_i[31:28]),
    .pad_in  (instr_i[15:4]),
    .rt_in   (instr_i[19:16]),
    .rd_we   (rd_we_o),
    .mem_rd  (mem_rd_o),
    .mem_wr  (mem_wr_o),
    .branch  (branch_o),
    .jal     (jal_o),
    .illegal (illegal_o),
    .wb_sel  (wb_sel_o),
    .rt_en   (rt_en_o),
    .rt_idx  (rt_idx_o)
);

// File: tb/tb_instr_decoder.sv
module tb_instr_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] pc_i = '0;
    logic [3:0]  rs_idx_o, rt_idx_o, rd_idx_o, sec_op_o;
    logic        rs_en_o, rt_en_o, rd_we_o, alu_imm_o, mem_rd_o, mem_wr_o;
    logic        branch_o, jal_o, illegal_o;
    logic [1:0]  wb_sel_o;
    logic [31:0] imm_o, br_target_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_decoder dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .pc_i(pc_i),
        .rs_idx_o(rs_idx_o), .rs_en_o(rs_en_o), .rt_idx_o(rt_idx_o), .rt_en_o(rt_en_o),
        .rd_idx_o(rd_idx_o), .rd_we_o(rd_we_o), .sec_op_o(sec_op_o), .imm_o(imm_o),
        .wb_sel_o(wb_sel_o), .alu_imm_o(alu_imm_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .branch_o(branch_o), .jal_o(jal_o), .illegal_o(illegal_o), .br_target_o(br_target_o)
    );

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                        input logic [3:0] rs, input logic [3:0] rt,
                                        input logic [15:0] imm);
        return {op, rd, rs, rt, imm};
    endfunction

    // Apply on a falling edge; result is registered at the next rising edge
    // and sampled at the falling edge after it.
    task automatic apply(input logic [31:0] w, input logic [31:0] pc);
        @(negedge clk);
        instr_i = w;
        pc_i    = pc;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] ers, input logic ersen,
                       input logic [3:0] ert, input logic erten, input logic [3:0] erd,
                       input logic ewe, input logic [3:0] esec, input logic [1:0] ewb,
                       input logic eai, input logic emr, input logic emw, input logic ebr,
                       input logic ejal, input logic eill);
        logic [26:0] act, exp;
        act = {rs_idx_o, rs_en_o, rt_idx_o, rt_en_o, rd_idx_o, rd_we_o, sec_op_o,
               wb_sel_o, alu_imm_o, mem_rd_o, mem_wr_o, branch_o, jal_o, illegal_o};
        exp = {ers, ersen, ert, erten, erd, ewe, esec, ewb, eai, emr, emw, ebr, ejal, eill};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: decode actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ill(input string req);
        chk(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        instr_i = enc(4'h0, 4'd5, 4'd3, 4'd7, 16'h0000);
        @(negedge clk);
        chk("R11 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk32("R11 reset imm", imm_o, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_alu_reg;
        apply(enc(4'h0, 4'd5, 4'd3, 4'd7, 16'h0006), 32'h0);
        chk("R2 xor", 3, 1, 7, 1, 5, 1, 4'h6, 2'd0, 0, 0, 0, 0, 0, 0);
        apply(enc(4'h0, 4'd1, 4'd2, 4'd4, 16'h000C), 32'h0);
        chk("R2 nand", 2, 1, 4, 1, 1, 1, 4'hC, 2'd0, 0, 0, 0, 0, 0, 0);
        apply(enc(4'h0, 4'd1, 4'd2, 4'd4, 16'h0010), 32'h0);
        chk_ill("R2 nonzero pad");
        apply(enc(4'h0, 4'd1, 4'd2, 4'd4, 16'h000B), 32'h0);
        chk_ill("R10 mvhi in reg alu");
    endtask

    task automatic t_compare;
        apply(enc(4'h2, 4'd9, 4'd10, 4'd11, 16'h0002), 32'h0);
        chk("R3 cmp reg lt", 10, 1, 11, 1, 9, 1, 4'h2, 2'd3, 0, 0, 0, 0, 0, 0);
        apply(enc(4'h2, 4'd9, 4'd10, 4'd11, 16'h0004), 32'h0);
        chk_ill("R10 cmp reg code 0100");
        apply(enc(4'hA, 4'd6, 4'd7, 4'hF, 16'h0005), 32'h0);
        chk("R3 cmpi gtz", 7, 1, 0, 0, 6, 1, 4'hF, 2'd3, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_alu_imm;
        apply(enc(4'h8, 4'd1, 4'd2, 4'hB, 16'h8001), 32'h0);
        chk("R4 mvhi", 2, 1, 0, 0, 1, 1, 4'hB, 2'd0, 1, 0, 0, 0, 0, 0);
        chk32("R1 negative imm", imm_o, 32'hFFFF8001);
        apply(enc(4'h8, 4'd1, 4'd2, 4'h3, 16'h7FFF), 32'h0);
        chk_ill("R10 alui code 0011");
        chk32("R1 positive imm on illegal", imm_o, 32'h00007FFF);
    endtask

    task automatic t_load;
        apply(enc(4'h9, 4'd4, 4'd14, 4'h0, 16'hFFFC), 32'h0);
        chk("R5 load word", 14, 1, 0, 0, 4, 1, 4'h0, 2'd1, 1, 1, 0, 0, 0, 0);
        apply(enc(4'h9, 4'd4, 4'd14, 4'h1, 16'hFFFC), 32'h0);
        chk_ill("R5 load code 0001");
    endtask

    task automatic t_store;
        apply(enc(4'h5, 4'h0, 4'd14, 4'd6, 16'h0008), 32'h0);
        chk("R6 store word", 14, 1, 6, 1, 0, 0, 4'h0, 2'd0, 1, 0, 1, 0, 0, 0);
        apply(enc(4'h5, 4'h2, 4'd14, 4'd6, 16'h0008), 32'h0);
        chk_ill("R6 store code 0010");
    endtask

    task automatic t_branch;
        apply(enc(4'h6, 4'h1, 4'd1, 4'd2, 16'hFFFE), 32'h0000_0100);
        chk("R7 beq", 1, 1, 2, 1, 0, 0, 4'h1, 2'd0, 0, 0, 0, 1, 0, 0);
        chk32("R7 back target", br_target_o, 32'h0000_00FC);
        apply(enc(4'h6, 4'h9, 4'd3, 4'd4, 16'h0003), 32'h0000_0040);
        chk32("R1 fwd target", br_target_o, 32'h0000_0050);
        apply(enc(4'h6, 4'hC, 4'd3, 4'd4, 16'h0003), 32'h0000_0040);
        chk_ill("R7 branch code 1100");
    endtask

    task automatic t_jal;
        apply(enc(4'hB, 4'd15, 4'd2, 4'h0, 16'h0004), 32'h0);
        chk("R8 jal", 2, 1, 0, 0, 15, 1, 4'h0, 2'd2, 1, 0, 0, 0, 1, 0);
        apply(enc(4'hB, 4'd15, 4'd2, 4'h1, 16'h0004), 32'h0);
        chk_ill("R8 jal code 0001");
    endtask

    task automatic t_bad_primary;
        logic [3:0] bad [8] = '{4'h1, 4'h3, 4'h4, 4'h7, 4'hC, 4'hD, 4'hE, 4'hF};
        for (int i = 0; i < 8; i++) begin
            apply(enc(bad[i], 4'd3, 4'd4, 4'd0, 16'h0000), 32'h0);
            chk_ill("R9 unassigned primary");
        end
        // legal word right after: decode recovers in one cycle
        apply(enc(4'h0, 4'd8, 4'd9, 4'd0, 16'h0001), 32'h0);
        chk("R12 sub with r0 source", 9, 1, 0, 1, 8, 1, 4'h1, 2'd0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
        $finish;
    end

    initial begin
        t_reset();
        t_alu_reg();
        t_compare();
        t_alu_imm();
        t_load();
        t_store();
        t_branch();
        t_jal();
        t_bad_primary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule